// File: doc/BRIEF.md
# Clock-Synthesizer Indirect Write Sequencer

This block loads a bank of clock-synthesizer control registers through a narrow indirect port. The port has two byte lanes: an address lane and a data lane. A single start pulse captures a full parameter set. The block then walks a fixed list of register updates. Each update is a three-cycle handshake. First the address lane carries the register index with the write-enable flag set. Next the data byte appears on the data lane while the address stays put. Last the address lane repeats the index with the flag cleared.

When the display-FIFO option is selected, two more byte writes follow the base list. The first loads the delay-lock control register, whose value depends on the DLL variant and the memory type. The second loads a fixed value into the video-FIFO control register. Two 32-bit word writes then go out on a separate word port. A small register file on the far side decodes the lanes the same way the clock block would. It exposes a read port and the two held words, so the whole programming run can be observed.

The controller moves through seven states:
- **S_IDLE** goes to **S_ADDR_WE** on *accept* (start while idle).
- **S_ADDR_WE** goes to **S_DATA** on *lane_data*.
- **S_DATA** goes to **S_ADDR_CLR** on *lane_clear*.
- **S_ADDR_CLR** goes back to **S_ADDR_WE** on *next_item*, or leaves on *items_end*. It goes to **S_WIDE_CFG** when the FIFO option is set and to **S_DONE** otherwise.
- **S_WIDE_CFG** goes to **S_WIDE_ONOFF** on *word_next*.
- **S_WIDE_ONOFF** goes to **S_DONE** on *word_end*.
- **S_DONE** goes to **S_IDLE** on *release*.

Top module: `pll_prog_seq`

## Requirements
- R1: After reset, busy, done, both lanes, the word port, the two held words and every far-side register read as zero.
- R2: Every address-lane value the block drives has bit 0 equal to 0 and bit 1 as the write-enable flag; bits 7:2 hold the register index.
- R3: Each byte write takes exactly three consecutive cycles. In the first, the address lane is {index, 2'b10} and the data lane is 0. In the second, the address lane is unchanged and the data lane holds the value. In the third, the address lane is {index, 2'b00} and the data lane is 0.
- R4: The base writes go out in this order, with these indices: reference divider 0x02, general control 0x03, memory-clock feedback 0x04, video-clock control 0x05, video-clock post divider 0x06, video-clock-0 feedback 0x07, extended control 0x0B.
- R5: With fifo_en set, two byte writes follow the base list. The first goes to index 0x0C with value 0x80 if dll_new is set, else 0xA6 if mem_sdram is set, else 0xA0. The second goes to index 0x0D with value 0x1B.
- R6: With fifo_en set, two word-port cycles follow the byte writes. The first has word_we=1, word_sel=0 and the FIFO configuration word. The second has word_we=1, word_sel=1 and the on/off word. The far side holds each word on its own output.
- R7: The far-side file stores the data lane into the register at address bits 7:2 only in cycles where address bit 1 is set. Indices that are never addressed stay zero. rd_data shows the register at rd_idx in the same cycle.
- R8: busy rises in the cycle after an accepted start. It stays high for 22 cycles with fifo_en clear and 30 cycles with fifo_en set; both counts include the done cycle.
- R9: done is high for exactly one cycle, and that cycle is the last one with busy high.
- R10: A start pulse while busy is high, including the done cycle, is ignored: the run and the lanes are not affected, and no new run begins.
- R11: All parameter inputs are sampled at the accepted start. Changes to them during a run have no effect on the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| ref_div | input | 8 | Reference divider value |
| gen_ctl | input | 8 | General control value |
| mclk_fb | input | 8 | Memory-clock feedback divider value |
| vclk_ctl | input | 8 | Video-clock control value |
| vclk_post | input | 8 | Video-clock post divider value |
| vclk0_fb | input | 8 | Video-clock-0 feedback divider value |
| ext_ctl | input | 8 | Extended control value |
| fifo_cfg | input | 32 | FIFO configuration word |
| fifo_onoff | input | 32 | FIFO on/off word |
| fifo_en | input | 1 | Enables the display-FIFO extra writes |
| dll_new | input | 1 | Selects the newer DLL variant value |
| mem_sdram | input | 1 | Memory is SDRAM |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pll_addr | output | 8 | Address byte lane |
| pll_data | output | 8 | Data byte lane |
| word_we | output | 1 | 32-bit word write strobe |
| word_sel | output | 1 | Word select: 0 configuration, 1 on/off |
| word_data | output | 32 | 32-bit word being written |
| rd_idx | input | 6 | Far-side read index |
| rd_data | output | 8 | Far-side register at rd_idx |
| cfg_word_q | output | 32 | Far-side held configuration word |
| onoff_word_q | output | 32 | Far-side held on/off word |

## Verification
Two collisions are forced, each a start request against a cycle that is already doing work. The first is a start pulse in the middle of a byte write, sent together with a changed parameter set that also flips the FIFO option. The second is a start pulse in the done cycle itself. In both cases the lane trace, cycle by cycle, must still match the list computed from the first parameter set. After the done cycle, busy must fall and stay low. All eight option combinations are swept with two data patterns each, and every one of the 64 far-side registers is read back after each run.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    localparam int LANE_W  = 8;
    localparam int IDX_W   = LANE_W - 2;
    localparam int WORD_W  = 32;
    localparam int N_BASE  = 7;
    localparam int N_EXTRA = 2;
    localparam int N_ITEMS = N_BASE + N_EXTRA;
    localparam int ITEM_W  = $clog2(N_ITEMS);
    localparam int N_REGS  = 1 << IDX_W;

    localparam logic [IDX_W-1:0] IX_REF  = 6'h02;
    localparam logic [IDX_W-1:0] IX_GEN  = 6'h03;
    localparam logic [IDX_W-1:0] IX_MFB  = 6'h04;
    localparam logic [IDX_W-1:0] IX_VCTL = 6'h05;
    localparam logic [IDX_W-1:0] IX_VPST = 6'h06;
    localparam logic [IDX_W-1:0] IX_V0FB = 6'h07;
    localparam logic [IDX_W-1:0] IX_EXT  = 6'h0B;
    localparam logic [IDX_W-1:0] IX_DLL  = 6'h0C;
    localparam logic [IDX_W-1:0] IX_VFC  = 6'h0D;

    localparam logic [LANE_W-1:0] DLL_NEW_V   = 8'h80;
    localparam logic [LANE_W-1:0] DLL_SDRAM_V = 8'hA6;
    localparam logic [LANE_W-1:0] DLL_DRAM_V  = 8'hA0;
    localparam logic [LANE_W-1:0] VFC_V       = 8'h1B;

    typedef struct packed {
        logic [LANE_W-1:0] ref_div;
        logic [LANE_W-1:0] gen_ctl;
        logic [LANE_W-1:0] mclk_fb;
        logic [LANE_W-1:0] vclk_ctl;
        logic [LANE_W-1:0] vclk_post;
        logic [LANE_W-1:0] vclk0_fb;
        logic [LANE_W-1:0] ext_ctl;
        logic [WORD_W-1:0] fifo_cfg;
        logic [WORD_W-1:0] fifo_onoff;
        logic              fifo_en;
        logic              dll_new;
        logic              mem_sdram;
    } pll_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR_WE, S_DATA, S_ADDR_CLR, S_WIDE_CFG, S_WIDE_ONOFF, S_DONE
    } seq_state_t;
endpackage

// File: rtl/pll_seq_items.sv
module pll_seq_items
    import pll_seq_pkg::*;
(
    input  pll_cfg_t          cfg,
    input  logic [ITEM_W-1:0] item,
    output logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] val
);
    logic [LANE_W-1:0] dll_val;

    always_comb begin
        if (cfg.dll_new)        dll_val = DLL_NEW_V;
        else if (cfg.mem_sdram) dll_val = DLL_SDRAM_V;
        else                    dll_val = DLL_DRAM_V;
    end

    always_comb begin
        unique case (item)
            4'd0:    begin idx = IX_REF;  val = cfg.ref_div;   end
            4'd1:    begin idx = IX_GEN;  val = cfg.gen_ctl;   end
            4'd2:    begin idx = IX_MFB;  val = cfg.mclk_fb;   end
            4'd3:    begin idx = IX_VCTL; val = cfg.vclk_ctl;  end
            4'd4:    begin idx = IX_VPST; val = cfg.vclk_post; end
            4'd5:    begin idx = IX_V0FB; val = cfg.vclk0_fb;  end
            4'd6:    begin idx = IX_EXT;  val = cfg.ext_ctl;   end
            4'd7:    begin idx = IX_DLL;  val = dll_val;       end
            4'd8:    begin idx = IX_VFC;  val = VFC_V;         end
            default: begin idx = '0;      val = '0;            end
        endcase
    end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  pll_cfg_t          cfg_in,
    input  logic [IDX_W-1:0]  item_idx,
    input  logic [LANE_W-1:0] item_val,
    output pll_cfg_t          snap,
    output logic [ITEM_W-1:0] item,
    output logic              busy,
    output logic              done,
    output logic [LANE_W-1:0] pll_addr,
    output logic [LANE_W-1:0] pll_data,
    output logic              word_we,
    output logic              word_sel,
    output logic [WORD_W-1:0] word_data
);
    seq_state_t state, state_nx;
    logic [ITEM_W-1:0] last_item;

    assign last_item = snap.fifo_en ? ITEM_W'(N_ITEMS - 1) : ITEM_W'(N_BASE - 1);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (start) state_nx = S_ADDR_WE;
            S_ADDR_WE:    state_nx = S_DATA;
            S_DATA:       state_nx = S_ADDR_CLR;
            S_ADDR_CLR: begin
                if (item != last_item)  state_nx = S_ADDR_WE;
                else if (snap.fifo_en)  state_nx = S_WIDE_CFG;
                else                    state_nx = S_DONE;
            end
            S_WIDE_CFG:   state_nx = S_WIDE_ONOFF;
            S_WIDE_ONOFF: state_nx = S_DONE;
            S_DONE:       state_nx = S_IDLE;
            default:      state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            item  <= '0;
            snap  <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start) begin
                snap <= cfg_in;
                item <= '0;
            end else if (state == S_ADDR_CLR && item != last_item) begin
                item <= item + 1'b1;
            end
        end
    end

    always_comb begin
        pll_addr  = '0;
        pll_data  = '0;
        word_we   = 1'b0;
        word_sel  = 1'b0;
        word_data = '0;
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        unique case (state)
            S_ADDR_WE:    pll_addr = {item_idx, 2'b10};
            S_DATA: begin
                pll_addr = {item_idx, 2'b10};
                pll_data = item_val;
            end
            S_ADDR_CLR:   pll_addr = {item_idx, 2'b00};
            S_WIDE_CFG: begin
                word_we   = 1'b1;
                word_data = snap.fifo_cfg;
            end
            S_WIDE_ONOFF: begin
                word_we   = 1'b1;
                word_sel  = 1'b1;
                word_data = snap.fifo_onoff;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pll_far_regs.sv
module pll_far_regs
    import pll_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] pll_addr,
    input  logic [LANE_W-1:0] pll_data,
    input  logic              word_we,
    input  logic              word_sel,
    input  logic [WORD_W-1:0] word_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LANE_W-1:0] rd_data,
    output logic [WORD_W-1:0] cfg_word_q,
    output logic [WORD_W-1:0] onoff_word_q
);
    logic [LANE_W-1:0] regs [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (pll_addr[1] && pll_addr[LANE_W-1:2] == IDX_W'(g))
                regs[g] <= pll_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_word_q   <= '0;
            onoff_word_q <= '0;
        end else if (word_we) begin
            if (word_sel) onoff_word_q <= word_data;
            else          cfg_word_q   <= word_data;
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
    import pll_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  ref_div,
    input  logic [7:0]  gen_ctl,
    input  logic [7:0]  mclk_fb,
    input  logic [7:0]  vclk_ctl,
    input  logic [7:0]  vclk_post,
    input  logic [7:0]  vclk0_fb,
    input  logic [7:0]  ext_ctl,
    input  logic [31:0] fifo_cfg,
    input  logic [31:0] fifo_onoff,
    input  logic        fifo_en,
    input  logic        dll_new,
    input  logic        mem_sdram,
    output logic        busy,
    output logic        done,
    output logic [7:0]  pll_addr,
    output logic [7:0]  pll_data,
    output logic        word_we,
    output logic        word_sel,
    output logic [31:0] word_data,
    input  logic [5:0]  rd_idx,
    output logic [7:0]  rd_data,
    output logic [31:0] cfg_word_q,
    output logic [31:0] onoff_word_q
);
    pll_cfg_t          cfg_in, snap;
    logic [ITEM_W-1:0] item;
    logic [IDX_W-1:0]  item_idx;
    logic [LANE_W-1:0] item_val;

    assign cfg_in = '{ref_div: ref_div, gen_ctl: gen_ctl, mclk_fb: mclk_fb,
                      vclk_ctl: vclk_ctl, vclk_post: vclk_post, vclk0_fb: vclk0_fb,
                      ext_ctl: ext_ctl, fifo_cfg: fifo_cfg, fifo_onoff: fifo_onoff,
                      fifo_en: fifo_en, dll_new: dll_new, mem_sdram: mem_sdram};

    pll_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
        .item_idx(item_idx), .item_val(item_val), .snap(snap), .item(item),
        .busy(busy), .done(done), .pll_addr(pll_addr), .pll_data(pll_data),
        .word_we(word_we), .word_sel(word_sel), .word_data(word_data)
    );

    pll_seq_items u_items (
        .cfg(snap), .item(item), .idx(item_idx), .val(item_val)
    );

    pll_far_regs u_far (
        .clk(clk), .rst_n(rst_n), .pll_addr(pll_addr), .pll_data(pll_data),
        .word_we(word_we), .word_sel(word_sel), .word_data(word_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .cfg_word_q(cfg_word_q),
        .onoff_word_q(onoff_word_q)
    );
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [7:0] pll_addr,
    input logic       word_we
);
    // R2
    addr_bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_addr[0] == 1'b0);

    // R3
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_addr[1]) |=> pll_addr[1] && $stable(pll_addr));

    // R3
    we_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_addr[1] && $past(pll_addr[1]) |=>
            !pll_addr[1] && pll_addr[7:2] == $past(pll_addr[7:2]));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R8
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy);

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy);

    // R6
    word_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_we |-> busy && !done);
endmodule

bind pll_prog_seq pll_seq_chk i_pll_seq_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pll_addr(pll_addr), .word_we(word_we)
);

// File: tb/test_pll_prog_seq.sv
module test_pll_prog_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ref_div = '0, gen_ctl = '0, mclk_fb = '0, vclk_ctl = '0;
    logic [7:0]  vclk_post = '0, vclk0_fb = '0, ext_ctl = '0;
    logic [31:0] fifo_cfg = '0, fifo_onoff = '0;
    logic        fifo_en = 1'b0, dll_new = 1'b0, mem_sdram = 1'b0;
    logic        busy, done, word_we, word_sel;
    logic [7:0]  pll_addr, pll_data, rd_data;
    logic [31:0] word_data, cfg_word_q, onoff_word_q;
    logic [5:0]  rd_idx = '0;

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0]  ex_addr [32];
    logic [7:0]  ex_data [32];
    logic [33:0] ex_word [32];
    logic [7:0]  ex_reg  [64];
    int          ex_len;

    always #5 clk = ~clk;

    pll_prog_seq i_pll_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_div(ref_div), .gen_ctl(gen_ctl),
        .mclk_fb(mclk_fb), .vclk_ctl(vclk_ctl), .vclk_post(vclk_post),
        .vclk0_fb(vclk0_fb), .ext_ctl(ext_ctl), .fifo_cfg(fifo_cfg),
        .fifo_onoff(fifo_onoff), .fifo_en(fifo_en), .dll_new(dll_new),
        .mem_sdram(mem_sdram), .busy(busy), .done(done), .pll_addr(pll_addr),
        .pll_data(pll_data), .word_we(word_we), .word_sel(word_sel),
        .word_data(word_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .cfg_word_q(cfg_word_q), .onoff_word_q(onoff_word_q)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R4/R5 index order and values, computed from the requirement text
    task automatic add_write(input int pos, input logic [5:0] ix, input logic [7:0] v);
        ex_addr[pos]   = {ix, 2'b10}; ex_data[pos]   = 8'h00; ex_word[pos]   = '0;
        ex_addr[pos+1] = {ix, 2'b10}; ex_data[pos+1] = v;     ex_word[pos+1] = '0;
        ex_addr[pos+2] = {ix, 2'b00}; ex_data[pos+2] = 8'h00; ex_word[pos+2] = '0;
        ex_reg[ix] = v;
    endtask

    task automatic build_expect();
        logic [5:0] ixs [9];
        logic [7:0] vs  [9];
        int nw;
        ixs = '{6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h0B, 6'h0C, 6'h0D};
        vs[0] = ref_div; vs[1] = gen_ctl; vs[2] = mclk_fb; vs[3] = vclk_ctl;
        vs[4] = vclk_post; vs[5] = vclk0_fb; vs[6] = ext_ctl;
        vs[7] = dll_new ? 8'h80 : (mem_sdram ? 8'hA6 : 8'hA0);
        vs[8] = 8'h1B;
        for (int i = 0; i < 64; i++) ex_reg[i] = 8'h00;
        nw = fifo_en ? 9 : 7;
        for (int i = 0; i < nw; i++) add_write(3*i, ixs[i], vs[i]);
        ex_len = 3*nw;
        if (fifo_en) begin
            ex_addr[ex_len] = 0; ex_data[ex_len] = 0; ex_word[ex_len] = {2'b10, fifo_cfg};
            ex_addr[ex_len+1] = 0; ex_data[ex_len+1] = 0; ex_word[ex_len+1] = {2'b11, fifo_onoff};
            ex_len += 2;
        end
        ex_addr[ex_len] = 0; ex_data[ex_len] = 0; ex_word[ex_len] = '0;
        ex_len += 1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy/done", {busy, done}, 0);
        check("R1 lanes", {pll_addr, pll_data, word_we, word_sel, word_data}, 0);
        check("R1 held words", {cfg_word_q, onoff_word_q}, 0);
    endtask

    task automatic run(input int seed, input bit f, input bit d, input bit s);
        logic [31:0] keep_cfg, keep_onoff;
        int n;
        ref_div   = 8'(seed*37 + 1) ^ 8'hA5;  gen_ctl  = 8'(seed*53 + 2);
        mclk_fb   = 8'(seed*71 + 3) ^ 8'h3C;  vclk_ctl = 8'(seed*19 + 4);
        vclk_post = 8'(seed*29 + 5) ^ 8'h5A;  vclk0_fb = 8'(seed*83 + 6);
        ext_ctl   = 8'(seed*97 + 7) ^ 8'hC3;
        fifo_cfg  = 32'(seed) * 32'h01234567 + 32'h89AB;
        fifo_onoff = 32'(seed) * 32'h7654321 ^ 32'hF0F0F0F0;
        fifo_en = f; dll_new = d; mem_sdram = s;
        keep_cfg = fifo_cfg; keep_onoff = fifo_onoff;
        build_expect();
        do_reset();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < 40) begin
            check("R3/R4/R5 addr lane", pll_addr, (n < ex_len) ? ex_addr[n] : 8'hxx);
            check("R3/R4/R5 data lane", pll_data, (n < ex_len) ? ex_data[n] : 8'hxx);
            check("R6 word port", {word_we, word_sel, word_data}, (n < ex_len) ? ex_word[n] : 'x);
            check("R9 done timing", done, n == ex_len - 1);
            if (n == 4) begin
                // R10 R11: competing start with altered parameters mid-run
                ref_div = ~ref_div; ext_ctl = ~ext_ctl; fifo_en = ~fifo_en;
                dll_new = ~dll_new; fifo_cfg = ~fifo_cfg; start = 1'b1;
            end
            if (n == 5) start = 1'b0;
            if (done) start = 1'b1;
            n++;
            @(negedge clk);
        end
        check("R8 busy length", n, ex_len);
        check("R10 no restart after done", {busy, pll_addr}, 0);
        start = 1'b0;
        @(negedge clk);
        check("R10 stays idle", {busy, done}, 0);
        for (int i = 0; i < 64; i++) begin
            rd_idx = 6'(i);
            #1;
            check("R7 far register", rd_data, ex_reg[i]);
        end
        check("R6 held cfg", cfg_word_q, f ? keep_cfg : 32'h0);
        check("R6 held onoff", onoff_word_q, f ? keep_onoff : 32'h0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 8; c++)
                run(p*8 + c + 1, c[2], c[1], c[0]);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule